// File: doc/BRIEF.md
# SPI Bit-Clock Divider with Linear and Power-of-Two Laws

This block turns a fast module clock into the timing strobes that pace an SPI shift engine. It never produces a second clock: it drives a registered SCLK level that always has a 50% duty cycle, a one-cycle toggle strobe at every SCLK transition, and separate one-cycle strobes that mark the rising and the falling transition. The shift engine uses these strobes as clock enables.

The division is set by one control word. The word holds two divisor fields and a law-select bit. The linear law divides by an even number, 2*(N+1). The power-of-two law divides by 2^M. Either way the module clock runs at least twice as fast as SCLK. A `run` input frames each burst. While `run` is low, the divider sits cleared with SCLK low and it copies the control word. While `run` is high, the copied setting is frozen and the counter paces SCLK from the first cycle of the burst.

Top module: `spi_sclk_divider`

## Requirements
- R1: With bit 12 of `cfg_word` set (linear law), SCLK toggles once every N+1 module-clock cycles, where N is `cfg_word[7:0]`; bits 11:8 have no effect.
- R2: With bit 12 of `cfg_word` clear (power-of-two law) and M = `cfg_word[11:8]` of 1 or more, SCLK toggles every 2^(M-1) cycles, giving a division of 2^M; bits 7:0 have no effect.
- R3: In power-of-two law with M = 0, the division is 2, so SCLK toggles every cycle.
- R4: In linear law with N = 0, the division is 2, so SCLK toggles every cycle.
- R5: After `run` rises, the first toggle appears at the output after exactly H rising clock edges that sampled `run` high, where H is the half period. This first transition is a rising edge of SCLK.
- R6: Within one cycle of a clock edge that samples `run` low, `sclk`, `sclk_toggle`, `sclk_rise` and `sclk_fall` are all 0. The half-period count restarts from zero at the next burst.
- R7: A change to `cfg_word` while `run` is high does not alter the toggle spacing of the running burst. The new value takes effect at the next burst.
- R8: `sclk_rise` pulses for one cycle exactly when SCLK has just gone from 0 to 1, and `sclk_fall` exactly when it has just gone from 1 to 0. Each of them coincides with `sclk_toggle`, and they are never high together.
- R9: While `rst` is high at a clock edge, all outputs are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High for the duration of a burst; low holds the divider cleared |
| cfg_word | input | 13 | Bits 7:0 linear divisor N, bits 11:8 exponent M, bit 12 law select (1 = linear) |
| sclk | output | 1 | Registered SCLK level, idle low |
| sclk_toggle | output | 1 | One-cycle strobe on every SCLK transition |
| sclk_rise | output | 1 | One-cycle strobe when SCLK has just risen |
| sclk_fall | output | 1 | One-cycle strobe when SCLK has just fallen |

## Verification
The bench drives both ends of each law: N = 0, N = 255, M = 0, M = 1 and M = 15. It checks the full strobe pattern on every cycle of a burst. A design that used 2^M as the half period, or that wrapped the exponent at M = 0, would space its toggles wrongly or divide by a huge count. Bursts are cut off part-way through a half period, including once with SCLK high. This exposes a counter that is not cleared, or an SCLK left high, because the next first toggle would arrive early. Another burst rewrites the control word mid-burst and then reuses the new value. This catches a design that reads the word live instead of at burst start. The opposite field of each law is loaded with nonzero values, so a bad field decode shows up as a wrong spacing.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  typedef struct packed {
    logic level;
    logic toggle;
    logic rise;
    logic fall;
  } sclk_out_t;

  function automatic int unsigned half_width(input int unsigned lin_w,
                                             input int unsigned exp_w);
    int unsigned pow_w;
    pow_w = (1 << exp_w) - 1;
    return (lin_w + 1 > pow_w) ? lin_w + 1 : pow_w;
  endfunction

endpackage

// File: rtl/sclk_div_cfg.sv
module sclk_div_cfg
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W  = 8,
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned CFG_W  = LIN_W + EXP_W + 1,
  parameter int unsigned HALF_W = half_width(LIN_W, EXP_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [HALF_W-1:0] half_q
);

  localparam int unsigned SEL_BIT = LIN_W + EXP_W;

  logic [LIN_W-1:0]  lin_n;
  logic [EXP_W-1:0]  exp_m;
  div_law_e          law;
  logic [HALF_W-1:0] lin_half;
  logic [HALF_W-1:0] pow_half;
  logic [HALF_W-1:0] half_d;

  assign lin_n = cfg_word[LIN_W-1:0];
  assign exp_m = cfg_word[SEL_BIT-1:LIN_W];
  assign law   = div_law_e'(cfg_word[SEL_BIT]);

  // Linear law: half period of N+1 cycles.
  assign lin_half = HALF_W'(lin_n) + HALF_W'(1);

  // Power-of-two law: half period of 2^(M-1) cycles, floor of one cycle.
  always_comb begin
    if (exp_m == '0) begin
      pow_half = HALF_W'(1);
    end else begin
      pow_half = HALF_W'(1) << (exp_m - EXP_W'(1));
    end
  end

  assign half_d = (law == LAW_LINEAR) ? lin_half : pow_half;

  // Setting follows the word while idle and freezes for the burst.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_W'(1);
    end else if (!run) begin
      half_q <= half_d;
    end
  end

endmodule

// File: rtl/sclk_div_count.sv
module sclk_div_count #(
  parameter int unsigned HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              wrap
);

  logic [HALF_W-1:0] cnt;

  assign wrap = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

endmodule

// File: rtl/sclk_div_edge.sv
module sclk_div_edge
  import sclk_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      wrap,
  output sclk_out_t outs
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      outs <= '0;
    end else begin
      outs.toggle <= wrap;
      outs.rise   <= wrap && !outs.level;
      outs.fall   <= wrap && outs.level;
      if (wrap) begin
        outs.level <= !outs.level;
      end
    end
  end

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  localparam int unsigned CFG_W  = LIN_W + EXP_W + 1,
  localparam int unsigned HALF_W = half_width(LIN_W, EXP_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             sclk,
  output logic             sclk_toggle,
  output logic             sclk_rise,
  output logic             sclk_fall
);

  logic [HALF_W-1:0] half_q;
  logic              wrap;
  sclk_out_t         outs;

  sclk_div_cfg #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CFG_W (CFG_W),
    .HALF_W(HALF_W)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cfg_word(cfg_word),
    .half_q  (half_q)
  );

  sclk_div_count #(
    .HALF_W(HALF_W)
  ) u_count (
    .clk (clk),
    .rst (rst),
    .run (run),
    .half(half_q),
    .wrap(wrap)
  );

  sclk_div_edge u_edge (
    .clk (clk),
    .rst (rst),
    .run (run),
    .wrap(wrap),
    .outs(outs)
  );

  assign sclk        = outs.level;
  assign sclk_toggle = outs.toggle;
  assign sclk_rise   = outs.rise;
  assign sclk_fall   = outs.fall;

endmodule

// File: rtl/sclk_div_checker.sv
module sclk_div_checker #(
  parameter int unsigned HALF_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [HALF_W-1:0] half_q,
  input logic              sclk,
  input logic              sclk_toggle,
  input logic              sclk_rise,
  input logic              sclk_fall
);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sclk && !sclk_toggle && !sclk_rise && !sclk_fall));

  assert_rise_fall_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sclk_rise, sclk_fall}));

  assert_rise_level_R8: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |-> (sclk && sclk_toggle && !$past(sclk)));

  assert_fall_level_R8: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |-> (!sclk && sclk_toggle && $past(sclk)));

  assert_hold_between_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !sclk_toggle) |-> $stable(sclk));

  assert_setting_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    $past(run) |-> $stable(half_q));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!sclk && !sclk_toggle));

endmodule

bind spi_sclk_divider sclk_div_checker #(
  .HALF_W(HALF_W)
) u_sclk_div_checker (
  .clk        (clk),
  .rst        (rst),
  .run        (run),
  .half_q     (half_q),
  .sclk       (sclk),
  .sclk_toggle(sclk_toggle),
  .sclk_rise  (sclk_rise),
  .sclk_fall  (sclk_fall)
);

// File: tb/test_spi_sclk_divider.sv
module test_spi_sclk_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [12:0] cfg_word = '0;
  logic        sclk, sclk_toggle, sclk_rise, sclk_fall;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_sclk_divider i_spi_sclk_divider (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cfg_word   (cfg_word),
    .sclk       (sclk),
    .sclk_toggle(sclk_toggle),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall)
  );

  function automatic logic [12:0] lin_cfg(input int n, input int junk_m);
    return {1'b1, 4'(junk_m), 8'(n)};
  endfunction

  function automatic logic [12:0] pow_cfg(input int m, input int junk_n);
    return {1'b0, 4'(m), 8'(junk_n)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Checks every cycle of a burst against the half-period model.
  task automatic burst(input logic [12:0] cfg, input int half, input int cycles,
                       input int chg_at, input logic [12:0] cfg2, input string req);
    int bad = 0;
    int first_bad_c = 0;
    int act_v = 0;
    int exp_v = 0;
    @(negedge clk);
    cfg_word = cfg;
    @(negedge clk);
    run = 1'b1;
    for (int c = 1; c <= cycles; c++) begin
      bit e_tgl;
      bit e_lvl;
      @(negedge clk);
      e_tgl = (c % half) == 0;
      e_lvl = ((c / half) % 2) == 1;
      if (sclk_toggle !== e_tgl || sclk !== e_lvl ||
          sclk_rise !== (e_tgl && e_lvl) || sclk_fall !== (e_tgl && !e_lvl)) begin
        if (bad == 0) begin
          first_bad_c = c;
          act_v = {sclk, sclk_toggle, sclk_rise, sclk_fall};
          exp_v = {e_lvl, e_tgl, e_tgl && e_lvl, e_tgl && !e_lvl};
        end
        bad++;
      end
      if (c == chg_at) cfg_word = cfg2;
    end
    check(bad == 0, req, $sformatf("strobe pattern (first bad cycle %0d, {lvl,tgl,rise,fall})",
          first_bad_c), act_v, exp_v);
    run = 1'b0;
    @(negedge clk);
    check(!sclk && !sclk_toggle && !sclk_rise && !sclk_fall, "R6",
          "outputs after run low", {sclk, sclk_toggle, sclk_rise, sclk_fall}, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    run = 1'b1;
    repeat (3) @(negedge clk);
    check(!sclk && !sclk_toggle && !sclk_rise && !sclk_fall, "R9", "outputs in reset",
          {sclk, sclk_toggle, sclk_rise, sclk_fall}, 0);
    run = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_linear();
    burst(lin_cfg(0, 9), 1, 8, 0, '0, "R4");
    burst(lin_cfg(4, 15), 5, 40, 0, '0, "R1");
    burst(lin_cfg(255, 3), 256, 1030, 0, '0, "R1");
  endtask

  task automatic test_pow2();
    burst(pow_cfg(0, 200), 1, 8, 0, '0, "R3");
    burst(pow_cfg(1, 77), 1, 8, 0, '0, "R2");
    burst(pow_cfg(3, 255), 4, 33, 0, '0, "R2");
    burst(pow_cfg(15, 0), 16384, 32770, 0, '0, "R2");
  endtask

  task automatic test_first_edge();
    // Cut with SCLK high, then mid-phase with SCLK low; each restart must be clean.
    burst(lin_cfg(4, 0), 5, 7, 0, '0, "R5");
    burst(lin_cfg(4, 0), 5, 13, 0, '0, "R5");
    burst(lin_cfg(4, 0), 5, 12, 0, '0, "R5");
  endtask

  task automatic test_midburst_change();
    burst(lin_cfg(2, 0), 3, 30, 4, lin_cfg(9, 0), "R7");
    // The word left on the bus applies only from the next burst.
    burst(lin_cfg(9, 0), 10, 41, 0, '0, "R7");
    burst(pow_cfg(2, 0), 2, 20, 1, lin_cfg(0, 0), "R7");
  endtask

  task automatic test_strobe_pairing();
    int rises = 0;
    int falls = 0;
    int both = 0;
    @(negedge clk);
    cfg_word = lin_cfg(1, 0);
    @(negedge clk);
    run = 1'b1;
    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      if (sclk_rise) rises++;
      if (sclk_fall) falls++;
      if (sclk_rise && sclk_fall) both++;
    end
    run = 1'b0;
    check(rises == 4 && falls == 4 && both == 0, "R8", "rise/fall counts (rises*100+falls)",
          rises * 100 + falls, 404);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_linear();
    test_pow2();
    test_first_edge();
    test_midburst_change();
    test_strobe_pairing();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule